// File: doc/BRIEF.md
# Compare-Restart Interval Timer Channel

This block is a single 16-bit timer channel that produces a periodic event. The clock that drives the count is chosen from four taps of an internal power-of-two prescaler, or from a slow-clock enable pulse that the system supplies. Each time the channel is clocked and the count equals a programmable compare value, a compare event occurs. When restart-on-compare is selected, the count then returns to zero, so the period is (compare value + 1) prescaled ticks.

A compare event sets a status flag. If the matching interrupt mask bit is set, the flag drives the interrupt line until software reads the status word; that read acknowledges the flag. A one-cycle debug pulse marks every compare event.

Software controls the channel through a small word-addressed register port. It has a start/stop command word, a mode word (clock source and restart-on-compare), the compare value, a read-only count, the status word, separate set and clear words for the interrupt mask, and a read-only view of that mask.

Top module: `interval_timer_chan`

## Requirements
- R1: After reset the count is 0, the channel is stopped, mode, compare value, status flag and mask are 0, and irq and dbg_tick are low.
- R2: A write to address 0 with bit 1 set stops the channel. While stopped, the count holds its value. A stop takes precedence over counting in the same cycle.
- R3: A write to address 0 with bit 0 set and bit 1 clear sets the count to 0 and starts the channel. If bits 0 and 1 are written together, the channel stops and the count is not cleared.
- R4: Mode bits [2:0] select the clock source. Values 0, 1, 2 and 3 give one tick every 2, 8, 32 or 128 cycles, on the cycles where (cycles since reset release) mod N equals N-1. Value 4 uses the slow_tick input. Values 5 to 7 give no ticks.
- R5: On each tick while the channel runs, a compare event occurs if the count equals the compare value. With mode bit 3 set, a compare event returns the count to 0. Otherwise the count increments and wraps from 65535 to 0.
- R6: A compare event sets status bit 0 in the next cycle. Status bit 8 shows whether the channel is running. A read of address 4 returns the status and clears bit 0, unless a new compare event occurs in that same cycle.
- R7: Writing 1 to bit 0 of address 5 sets the interrupt mask. Writing 1 to bit 0 of address 6 clears it. Address 7 returns the mask in bit 0. irq equals status bit 0 AND the mask.
- R8: dbg_tick is high for exactly the one cycle that follows each compare event.
- R9: Address 1 reads back the mode in bits [3:0]. Address 2 reads back the compare value. Address 3 returns the count, and writes to it are ignored. Addresses 0, 5 and 6 read as 0. bus_rdata is 0 whenever no read is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_tick | input | 1 | Slow-clock enable pulse, one cycle wide |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (combinational, valid while a read is presented) |
| irq | output | 1 | Interrupt request |
| dbg_tick | output | 1 | One-cycle pulse after each compare event |

## Verification
The bench compares every cycle, so a wrong count shows up at the next read of address 3, and as a dbg_tick pulse on the wrong cycle at the next compare. A prescaler out of phase moves the first compare event, and that shift shows on dbg_tick within one period of the selected tap. If the flag or mask are stale, irq differs from the bench model in the cycle after the compare event or the read that should have changed it. A read-clear that fails to clear, or that clears too much, shows the same way.

// File: rtl/itc_pkg.sv
package itc_pkg;
  localparam int NUM_TAPS  = 4;
  localparam int SEL_W     = 3;
  localparam int ADDR_W    = 3;
  localparam logic [SEL_W-1:0] SLOW_SEL = 3'd4;

  localparam logic [ADDR_W-1:0] A_CMD   = 3'd0;
  localparam logic [ADDR_W-1:0] A_MODE  = 3'd1;
  localparam logic [ADDR_W-1:0] A_CMPV  = 3'd2;
  localparam logic [ADDR_W-1:0] A_COUNT = 3'd3;
  localparam logic [ADDR_W-1:0] A_STAT  = 3'd4;
  localparam logic [ADDR_W-1:0] A_MSET  = 3'd5;
  localparam logic [ADDR_W-1:0] A_MCLR  = 3'd6;
  localparam logic [ADDR_W-1:0] A_MASK  = 3'd7;

  localparam int CMD_GO_BIT   = 0;
  localparam int CMD_HALT_BIT = 1;
  localparam int STAT_RUN_BIT = 8;

  typedef struct packed {
    logic             restart;
    logic [SEL_W-1:0] src;
  } mode_t;

  // Divider ratio of prescaler tap k: 2^(2k+1)
  function automatic int tap_ratio(input int k);
    return 2 << (2 * k);
  endfunction

  // Highest prescaler bit used by tap k
  function automatic int tap_msb(input int k);
    return 2 * k;
  endfunction

  // Next counter value after a tick
  function automatic logic [15:0] next_count(input logic [15:0] cur,
                                             input logic hit,
                                             input logic restart);
    if (hit && restart) return '0;
    return cur + 16'd1;
  endfunction
endpackage

// File: rtl/itc_prescale.sv
module itc_prescale
  import itc_pkg::*;
#(
  parameter int TAPS = NUM_TAPS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slow_tick,
  input  logic [SEL_W-1:0] src,
  output logic             tick
);
  localparam int PRE_W = tap_msb(TAPS - 1) + 1;

  logic [PRE_W-1:0] div_q;
  logic [TAPS-1:0]  tap_tick;

  always_ff @(posedge clk) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_q + 1'b1;
  end

  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    assign tap_tick[k] = &div_q[tap_msb(k):0];
    if (k > 0) begin : g_nest
      AST_TAP_NESTED: assert property (@(posedge clk) disable iff (!rst_n)
        tap_tick[k] |-> tap_tick[k-1]); // R4
    end
  end

  always_comb begin
    tick = 1'b0;
    if (int'(src) < TAPS)   tick = tap_tick[src[$clog2(TAPS)-1:0]];
    else if (src == SLOW_SEL) tick = slow_tick;
  end

  AST_DIV2_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
    tap_tick[0] |=> !tap_tick[0]); // R4
endmodule

// File: rtl/itc_counter.sv
module itc_counter
  import itc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             go_cmd,
  input  logic             halt_cmd,
  input  logic             restart,
  input  logic [CNT_W-1:0] cmp_val,
  output logic [CNT_W-1:0] count,
  output logic             running,
  output logic             cmp_evt
);
  logic hit;
  assign hit     = (count == cmp_val);
  assign cmp_evt = running && tick && hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count   <= '0;
      running <= 1'b0;
    end else if (halt_cmd) begin
      running <= 1'b0;
    end else if (go_cmd) begin
      count   <= '0;
      running <= 1'b1;
    end else if (running && tick) begin
      count <= next_count(count, hit, restart);
    end
  end

  AST_HALT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    halt_cmd |=> !running); // R3
  AST_GO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (go_cmd && !halt_cmd) |=> (running && count == '0)); // R3
  AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !go_cmd) |=> $stable(count)); // R2
  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_evt && restart && !halt_cmd && !go_cmd) |=> (count == '0)); // R5
endmodule

// File: rtl/itc_regs.sv
module itc_regs
  import itc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  input  logic [CNT_W-1:0]  count,
  input  logic              running,
  input  logic              cmp_evt,
  output mode_t             mode,
  output logic [CNT_W-1:0]  cmp_val,
  output logic              go_cmd,
  output logic              halt_cmd,
  output logic              flag,
  output logic              mask
);
  logic wr_en, rd_en, stat_rd;

  assign wr_en    = bus_sel && bus_wr;
  assign rd_en    = bus_sel && !bus_wr;
  assign stat_rd  = rd_en && (bus_addr == A_STAT);
  assign go_cmd   = wr_en && (bus_addr == A_CMD) && bus_wdata[CMD_GO_BIT];
  assign halt_cmd = wr_en && (bus_addr == A_CMD) && bus_wdata[CMD_HALT_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode    <= '0;
      cmp_val <= '0;
      mask    <= 1'b0;
    end else if (wr_en) begin
      case (bus_addr)
        A_MODE:  mode    <= mode_t'(bus_wdata[SEL_W:0]);
        A_CMPV:  cmp_val <= bus_wdata;
        A_MSET:  if (bus_wdata[0]) mask <= 1'b1;
        A_MCLR:  if (bus_wdata[0]) mask <= 1'b0;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       flag <= 1'b0;
    else if (cmp_evt) flag <= 1'b1;
    else if (stat_rd) flag <= 1'b0;
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_en) begin
      case (bus_addr)
        A_MODE:  bus_rdata[SEL_W:0] = mode;
        A_CMPV:  bus_rdata = cmp_val;
        A_COUNT: bus_rdata = count;
        A_STAT: begin
          bus_rdata[0]            = flag;
          bus_rdata[STAT_RUN_BIT] = running;
        end
        A_MASK:  bus_rdata[0] = mask;
        default: bus_rdata = '0;
      endcase
    end
  end

  AST_EVT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_evt |=> flag); // R6
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !cmp_evt) |=> !flag); // R6
  AST_IDLE_RDATA: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> (bus_rdata == '0)); // R9
endmodule

// File: rtl/interval_timer_chan.sv
module interval_timer_chan
  import itc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_tick,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              irq,
  output logic              dbg_tick
);
  mode_t            mode;
  logic [CNT_W-1:0] cmp_val, count;
  logic             tick, go_cmd, halt_cmd, running, cmp_evt, flag, mask;

  itc_prescale #(.TAPS(NUM_TAPS)) u_pre (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick),
    .src(mode.src), .tick(tick)
  );

  itc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .go_cmd(go_cmd),
    .halt_cmd(halt_cmd), .restart(mode.restart), .cmp_val(cmp_val),
    .count(count), .running(running), .cmp_evt(cmp_evt)
  );

  itc_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .count(count), .running(running), .cmp_evt(cmp_evt), .mode(mode),
    .cmp_val(cmp_val), .go_cmd(go_cmd), .halt_cmd(halt_cmd),
    .flag(flag), .mask(mask)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) dbg_tick <= 1'b0;
    else        dbg_tick <= cmp_evt;
  end

  assign irq = flag && mask;

  AST_DBG_FOLLOWS_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_evt |=> dbg_tick); // R8
  AST_DBG_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_tick && !$past(cmp_evt)) |-> 1'b0); // R8
  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (!mask) |-> !irq); // R7
endmodule

// File: tb/interval_timer_chan_tb.sv
module interval_timer_chan_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slow_tick = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq, dbg_tick;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;
  string phase = "R1";

  interval_timer_chan dut_i (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq), .dbg_tick(dbg_tick)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference state
  int m_pc, m_cnt, m_cmp, m_src;
  bit m_run, m_restart, m_flag, m_mask, m_dbg;

  function automatic bit model_tick();
    int n;
    if (m_src <= 3) begin
      n = 2 * (4 ** m_src);
      return (m_pc % n) == n - 1;
    end
    if (m_src == 4) return slow_tick;
    return 0;
  endfunction

  function automatic int exp_read(input int a);
    case (a)
      1: return m_src + (m_restart ? 8 : 0);
      2: return m_cmp;
      3: return m_cnt;
      4: return (m_run ? 256 : 0) + (m_flag ? 1 : 0);
      7: return m_mask ? 1 : 0;
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(input int a);
    case (a)
      1, 2: return "R9 mode/compare";
      3: return "R5 count";
      4: return "R6 status";
      7: return "R7 mask";
      default: return "R9 write-only";
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s [%s] t=%0t actual=%0d expected=%0d", tag, phase, $time, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pc = 0; m_cnt = 0; m_cmp = 0; m_src = 0;
      m_run = 0; m_restart = 0; m_flag = 0; m_mask = 0; m_dbg = 0;
    end else begin
      bit tk, evt, wr, rd;
      tk  = model_tick();
      evt = m_run && tk && (m_cnt == m_cmp);
      wr  = bus_sel && bus_wr;
      rd  = bus_sel && !bus_wr;
      if (wr && bus_addr == 0 && bus_wdata[1]) m_run = 0;
      else if (wr && bus_addr == 0 && bus_wdata[0]) begin m_cnt = 0; m_run = 1; end
      else if (m_run && tk) m_cnt = (evt && m_restart) ? 0 : (m_cnt + 1) % 65536;
      if (evt) m_flag = 1;
      else if (rd && bus_addr == 4) m_flag = 0;
      if (wr && bus_addr == 1) begin m_src = bus_wdata[2:0]; m_restart = bus_wdata[3]; end
      if (wr && bus_addr == 2) m_cmp = bus_wdata;
      if (wr && bus_addr == 5 && bus_wdata[0]) m_mask = 1;
      if (wr && bus_addr == 6 && bus_wdata[0]) m_mask = 0;
      m_dbg = evt;
      m_pc++;
    end
    #(CLK_PERIOD/4);
    check("R7 irq", irq, m_flag && m_mask);
    check("R8 dbg_tick", dbg_tick, m_dbg);
    if (bus_sel && !bus_wr) check(tag_of(bus_addr), bus_rdata, exp_read(bus_addr));
    else check("R9 idle rdata", bus_rdata, 0);
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a[2:0]; bus_wdata = d[15:0];
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input int a);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a[2:0];
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic poll(input int n, input int a);
    for (int i = 0; i < n; i++) rd(a);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    phase = "R1";
    for (int a = 0; a < 8; a++) rd(a);

    phase = "R5 div2 restart";
    wr(2, 3); wr(1, 8); wr(5, 1); wr(0, 1);
    poll(30, 3);
    poll(10, 4);

    phase = "R6 status read every cycle";
    wr(2, 0);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = 3'd4;
    repeat (20) @(negedge clk);
    bus_sel = 0;

    phase = "R4 div8";
    wr(1, 8 + 1); wr(2, 2); wr(0, 1);
    poll(60, 3); rd(4); idle(20); rd(4);

    phase = "R2 stop holds";
    wr(0, 2); idle(30); poll(3, 3); rd(4);

    phase = "R3 start and stop together";
    wr(0, 1); idle(10); wr(0, 3); poll(3, 3); rd(4);

    phase = "R5 no restart";
    wr(1, 0); wr(2, 5); wr(0, 1); poll(40, 3); rd(4);

    phase = "R4 div32";
    wr(1, 8 + 2); wr(2, 1); wr(0, 1); idle(200); rd(3); rd(4);

    phase = "R4 div128";
    wr(1, 8 + 3); wr(2, 0); wr(0, 1); idle(300); rd(3); rd(4);

    phase = "R4 slow tick";
    wr(1, 8 + 4); wr(2, 2); wr(0, 1);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk); slow_tick = 1;
      @(negedge clk); slow_tick = 0;
      idle(2); rd(3);
    end

    phase = "R4 reserved source";
    wr(1, 8 + 5); wr(0, 1); idle(40); rd(3);

    phase = "R7 mask clear";
    wr(1, 8); wr(2, 1); wr(0, 1); idle(10); rd(7);
    wr(6, 1); rd(7); idle(10); rd(4);

    phase = "R9 count write ignored";
    wr(0, 2); wr(3, 16'h1234); rd(3); rd(1); rd(2);

    idle(5);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end
endmodule